// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital control section of a sixteen-position trimming potentiometer. A host drives three slow control lines: an active-low select, a direction level and an active-low step strobe. While the block is selected, every falling edge of the step strobe moves a four-bit wiper position one place up or down. The position stops at either end of its range and does not wrap. The position is decoded into a one-hot tap select that drives the switch array. When the tap changes, the new switch closes for a few clock cycles before the old one opens.

A register models the nonvolatile cell. Releasing the select line while the step strobe is high copies the live position into that register. This starts a store interval that models the slow programming time, and all control lines are ignored until it ends. Releasing the select line while the step strobe is low leaves the register untouched. The live position still holds its value until the next change. A power-up reset reloads the live position from the register. A separate cold reset gives the register its factory value. The block rests in a low-power standby state after a store or a discard, and stays there until it is selected again. All three control lines are brought into the clock domain through two-stage synchronizers.

Top module: `tap_stepper`

## Requirements
- R1: After power-up reset the position equals the value held in the nonvolatile register (INIT_POS after a cold reset), the tap select is one-hot at that position, busy is 0 and standby is 1.
- R2: While selected (selN low) and not busy, each falling edge of stepN moves the position by exactly one: up when dirUp is 1, down when dirUp is 0.
- R3: The position saturates: an up step at 2**POS_W-1 leaves it there, and a down step at 0 leaves it at 0. It never jumps from one end to the other.
- R4: In steady state exactly one bit of tapSel is set, and it is bit number `position`. At every cycle, bit `position` is set and at most two bits are set.
- R5: When a step changes the position, tapSel holds both the old and the new bit for exactly OVL_CYCLES cycles, then only the new bit. A saturated step causes no overlap.
- R6: Falling edges of stepN while selN is high do not change the position.
- R7: A rising edge of selN while stepN is high copies the position into the nonvolatile register and raises busy for exactly STORE_CYCLES cycles. A later power-up reset restores that value.
- R8: A rising edge of selN while stepN is low stores nothing and does not raise busy. The live position keeps its value until reset, and reset then restores the previously stored value.
- R9: While busy, transitions on selN and stepN do not change the position.
- R10: standby is 1 after a store completes or after a discard, and stays 1 until the block is selected. It is 0 while the block is selected or busy. busy and standby are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| coldRstN | input | 1 | Active-low cold reset; loads INIT_POS into the nonvolatile register |
| rstN | input | 1 | Active-low power-up reset; reloads the position from the nonvolatile register |
| selN | input | 1 | Active-low select, asynchronous |
| dirUp | input | 1 | Step direction, 1 = up, asynchronous |
| stepN | input | 1 | Step strobe, active on the falling edge, asynchronous |
| position | output | POS_W | Live wiper position |
| tapSel | output | 2**POS_W | Tap switch enables; bit i closes tap i |
| busy | output | 1 | Store interval in progress |
| standby | output | 1 | Low-power standby state |

## Verification
The checker watches, on every cycle, that the position never moves by more than one place and never wraps. It also checks that the tap bit for the live position is always set with at most one other bit, that the position stays frozen during a store, that the register captures the position when busy rises, that no store runs longer than STORE_CYCLES, and that busy and standby never overlap. Some behaviours only the bench scenarios can show: the exact overlap length, the sweep past both ends, steps being ignored while deselected or busy, the store-versus-discard choice on release, and the value a reset restores.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic commit;
  } tapStrobe_t;

  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_STORING = 2'd2
  } ctrlState_t;

endpackage

// File: rtl/tap_sync.sv
module tap_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage1 <= RST_VAL[i];
        stage2 <= RST_VAL[i];
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int STORE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selSyncN,
  input  logic       dirSync,
  input  logic       stepSyncN,
  output tapStrobe_t strb,
  output logic       busy,
  output logic       standby
);

  localparam int CNT_W = $clog2(STORE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STORE_CYCLES - 1);

  ctrlState_t      state;
  logic [CNT_W-1:0] storeCnt;
  logic            prevSelN;
  logic            prevStepN;
  logic            selRise;
  logic            stepFall;

  assign selRise  = !prevSelN && selSyncN;
  assign stepFall = prevStepN && !stepSyncN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_STANDBY;
      storeCnt  <= '0;
      prevSelN  <= 1'b1;
      prevStepN <= 1'b1;
      strb      <= '0;
    end else begin
      prevSelN  <= selSyncN;
      prevStepN <= stepSyncN;
      strb      <= '0;
      case (state)
        ST_STANDBY: begin
          if (!selSyncN) state <= ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (selRise) begin
            if (stepSyncN) begin
              state       <= ST_STORING;
              storeCnt    <= '0;
              strb.commit <= 1'b1;
            end else begin
              state <= ST_STANDBY;
            end
          end else if (stepFall && !selSyncN) begin
            strb.stepUp   <= dirSync;
            strb.stepDown <= !dirSync;
          end
        end
        ST_STORING: begin
          if (storeCnt == CNT_LAST) state <= ST_STANDBY;
          else storeCnt <= storeCnt + 1'b1;
        end
        default: state <= ST_STANDBY;
      endcase
    end
  end

  assign busy    = (state == ST_STORING);
  assign standby = (state == ST_STANDBY);

endmodule

// File: rtl/tap_datapath.sv
module tap_datapath
  import tap_pkg::*;
#(
  parameter int POS_W      = 4,
  parameter int INIT_POS   = 8,
  parameter int OVL_CYCLES = 2
) (
  input  logic                  clk,
  input  logic                  coldRstN,
  input  logic                  rstN,
  input  tapStrobe_t            strb,
  output logic [POS_W-1:0]      position,
  output logic [POS_W-1:0]      nvValue,
  output logic [2**POS_W-1:0]   tapSel
);

  localparam int TAPS = 2 ** POS_W;
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] POS_MIN = '0;

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] nvReg;
  logic             moved;
  logic [TAPS-1:0]  newHot;
  logic [TAPS-1:0]  oldHot;

  assign moved = (strb.stepUp && pos != POS_MAX) || (strb.stepDown && pos != POS_MIN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos <= nvReg;
    end else if (strb.stepUp && pos != POS_MAX) begin
      pos <= pos + 1'b1;
    end else if (strb.stepDown && pos != POS_MIN) begin
      pos <= pos - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!coldRstN) nvReg <= POS_W'(INIT_POS);
    else if (strb.commit) nvReg <= pos;
  end

  for (genvar i = 0; i < TAPS; i++) begin : g_newTap
    assign newHot[i] = (pos == POS_W'(i));
  end

  if (OVL_CYCLES > 0) begin : g_overlap
    localparam int OVL_W = $clog2(OVL_CYCLES + 1);
    logic [OVL_W-1:0] ovlCnt;
    logic [POS_W-1:0] prevPos;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ovlCnt  <= '0;
        prevPos <= '0;
      end else if (moved) begin
        ovlCnt  <= OVL_W'(OVL_CYCLES);
        prevPos <= pos;
      end else if (ovlCnt != '0) begin
        ovlCnt <= ovlCnt - 1'b1;
      end
    end

    for (genvar i = 0; i < TAPS; i++) begin : g_oldTap
      assign oldHot[i] = (ovlCnt != '0) && (prevPos == POS_W'(i));
    end
  end else begin : g_noOverlap
    assign oldHot = '0;
  end

  assign tapSel   = newHot | oldHot;
  assign position = pos;
  assign nvValue  = nvReg;

endmodule

// File: rtl/tap_stepper.sv
module tap_stepper
  import tap_pkg::*;
#(
  parameter int POS_W        = 4,
  parameter int INIT_POS     = 8,
  parameter int STORE_CYCLES = 1000,
  parameter int OVL_CYCLES   = 2
) (
  input  logic                clk,
  input  logic                coldRstN,
  input  logic                rstN,
  input  logic                selN,
  input  logic                dirUp,
  input  logic                stepN,
  output logic [POS_W-1:0]    position,
  output logic [2**POS_W-1:0] tapSel,
  output logic                busy,
  output logic                standby
);

  logic [2:0]       syncBus;
  tapStrobe_t       strb;
  logic [POS_W-1:0] nvValue;

  tap_sync #(.W(3), .RST_VAL(3'b101)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({selN, dirUp, stepN}),
    .syncOut (syncBus)
  );

  tap_ctrl #(.STORE_CYCLES(STORE_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .selSyncN  (syncBus[2]),
    .dirSync   (syncBus[1]),
    .stepSyncN (syncBus[0]),
    .strb      (strb),
    .busy      (busy),
    .standby   (standby)
  );

  tap_datapath #(
    .POS_W      (POS_W),
    .INIT_POS   (INIT_POS),
    .OVL_CYCLES (OVL_CYCLES)
  ) u_dp (
    .clk      (clk),
    .coldRstN (coldRstN),
    .rstN     (rstN),
    .strb     (strb),
    .position (position),
    .nvValue  (nvValue),
    .tapSel   (tapSel)
  );

endmodule

// File: rtl/tap_stepper_chk.sv
module tap_stepper_chk #(
  parameter int POS_W        = 4,
  parameter int STORE_CYCLES = 1000
) (
  input logic                clk,
  input logic                rstN,
  input logic [POS_W-1:0]    position,
  input logic [POS_W-1:0]    nvValue,
  input logic [2**POS_W-1:0] tapSel,
  input logic                busy,
  input logic                standby
);

  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam int LEN_W = $clog2(STORE_CYCLES + 2);

  logic [LEN_W-1:0] busyLen;

  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else busyLen <= '0;
  end

  // R2: at most one place per cycle
  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, position} == {1'b0, $past(position)}) ||
    ({1'b0, position} == {1'b0, $past(position)} + 1'b1) ||
    ({1'b0, position} + 1'b1 == {1'b0, $past(position)}));

  assert_no_wrap_top_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(position) == POS_MAX) |-> (position != '0));

  assert_no_wrap_bottom_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(position) == '0) |-> (position != POS_MAX));

  assert_live_tap_R4: assert property (@(posedge clk) disable iff (!rstN)
    tapSel[position] && ($countones(tapSel) <= 2));

  assert_store_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> (nvValue == $past(position)));

  assert_store_length_R7: assert property (@(posedge clk) disable iff (!rstN)
    busyLen <= LEN_W'(STORE_CYCLES));

  assert_frozen_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(position));

  assert_mode_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && standby));

endmodule

bind tap_stepper tap_stepper_chk #(
  .POS_W        (POS_W),
  .STORE_CYCLES (STORE_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .position (position),
  .nvValue  (nvValue),
  .tapSel   (tapSel),
  .busy     (busy),
  .standby  (standby)
);

// File: tb/tap_stepper_test.sv
module tap_stepper_test;

  localparam int POS_W = 4;
  localparam int INIT_POS = 5;
  localparam int STORE_CYCLES = 40;
  localparam int OVL_CYCLES = 2;
  localparam int TOP = 2 ** POS_W - 1;

  logic clk = 1'b0;
  logic coldRstN = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1;
  logic dirUp = 1'b0;
  logic stepN = 1'b1;
  logic [POS_W-1:0] position;
  logic [2**POS_W-1:0] tapSel;
  logic busy;
  logic standby;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int expPos;

  tap_stepper #(
    .POS_W(POS_W), .INIT_POS(INIT_POS),
    .STORE_CYCLES(STORE_CYCLES), .OVL_CYCLES(OVL_CYCLES)
  ) uut (
    .clk(clk), .coldRstN(coldRstN), .rstN(rstN), .selN(selN),
    .dirUp(dirUp), .stepN(stepN), .position(position),
    .tapSel(tapSel), .busy(busy), .standby(standby)
  );

  always #2 clk = ~clk;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one step pulse; counts overlap cycles with old and new taps both on
  task automatic pulse(input bit up, output int ovl);
    int oldPos;
    int newPos;
    logic [2**POS_W-1:0] pair;
    oldPos = position;
    newPos = up ? ((oldPos < TOP) ? oldPos + 1 : TOP) : ((oldPos > 0) ? oldPos - 1 : 0);
    pair = (16'b1 << oldPos) | (16'b1 << newPos);
    ovl = 0;
    dirUp = up;
    waitClk(3);
    stepN = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (oldPos != newPos && tapSel == pair) ovl++;
    end
    stepN = 1'b1;
    waitClk(6);
  endtask

  task automatic sweepStep(input bit up, input bit sel);
    int ovl;
    int moved;
    int nxt;
    nxt = up ? ((expPos < TOP) ? expPos + 1 : TOP) : ((expPos > 0) ? expPos - 1 : 0);
    moved = (nxt != expPos);
    pulse(up, ovl);
    if (sel) begin
      expPos = nxt;
      check(position == expPos, "R2/R3 position after step", position, expPos);
      check(ovl == (moved ? OVL_CYCLES : 0), "R5 overlap cycles", ovl, moved ? OVL_CYCLES : 0);
    end else begin
      check(position == expPos, "R6 deselected step ignored", position, expPos);
    end
    check(tapSel == (16'b1 << expPos), "R4 single tap", tapSel, 1 << expPos);
  endtask

  initial begin
    int busyCnt;
    int ovlDummy;
    waitClk(5);
    coldRstN = 1'b1;
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);
    expPos = INIT_POS;
    check(position == INIT_POS, "R1 reset position", position, INIT_POS);
    check(tapSel == (16'b1 << INIT_POS), "R1 reset tap", tapSel, 1 << INIT_POS);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(standby == 1'b1, "R1 reset standby", standby, 1);

    sweepStep(1'b1, 1'b0);
    sweepStep(1'b0, 1'b0);

    selN = 1'b0;
    waitClk(6);
    check(standby == 1'b0, "R10 selected leaves standby", standby, 0);

    for (int i = 0; i < 7; i++) sweepStep(1'b0, 1'b1);
    for (int i = 0; i < 17; i++) sweepStep(1'b1, 1'b1);
    for (int i = 0; i < 6; i++) sweepStep(1'b0, 1'b1);
    check(position == 9, "R2 sweep end", position, 9);

    // store with step high; poke the lines during the store interval
    busyCnt = 0;
    selN = 1'b1;
    for (int k = 0; k < 80; k++) begin
      if (k == 10) selN = 1'b0;
      if (k == 12) begin dirUp = 1'b1; stepN = 1'b0; end
      if (k == 16) stepN = 1'b1;
      @(negedge clk);
      if (busy) busyCnt++;
    end
    check(busyCnt == STORE_CYCLES, "R7 busy length", busyCnt, STORE_CYCLES);
    check(position == 9, "R9 ignored while busy", position, 9);
    check(standby == 1'b0, "R10 selected after store", standby, 0);

    // store then stay deselected to see standby
    selN = 1'b1;
    waitClk(STORE_CYCLES + 10);
    check(busy == 1'b0 && standby == 1'b1, "R10 standby after store", standby, 1);
    selN = 1'b0;
    waitClk(6);

    // discard: step up, then hold step low (one more step) and release select
    pulse(1'b1, ovlDummy);
    check(position == 10, "R2 up before discard", position, 10);
    dirUp = 1'b1;
    waitClk(3);
    stepN = 1'b0;
    waitClk(6);
    check(position == 11, "R2 final falling edge", position, 11);
    selN = 1'b1;
    busyCnt = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (busy) busyCnt++;
    end
    check(busyCnt == 0, "R8 no store on discard", busyCnt, 0);
    check(standby == 1'b1, "R10 standby after discard", standby, 1);
    check(position == 11, "R8 live position kept", position, 11);
    stepN = 1'b1;
    waitClk(4);

    rstN = 1'b0;
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);
    check(position == 9, "R8/R7 reset restores stored", position, 9);
    check(tapSel == (16'b1 << 9), "R1 tap after reload", tapSel, 1 << 9);
    check(standby == 1'b1 && busy == 1'b0, "R1 modes after reload", standby, 1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule